// File: doc/BRIEF.md
# I2C register-access slave port

This block is an I2C slave that gives a bus master read and write access to a small internal register file. The block samples the SCL and SDA lines through two-stage synchronisers and finds bus events from the synchronised copies. It decodes START, repeated START and STOP. It answers one 7-bit slave address, and it indexes the register file through an internal pointer. The pointer also carries an auto-increment flag.

In a write transaction the first byte after the address sets the pointer. Every later byte is written to the register the pointer selects. In a read transaction the slave shifts out the selected register, most significant bit first. It keeps supplying bytes for as long as the master acknowledges them. The register file sits outside the block. It returns read data combinationally for the address presented. Each access appears as a single-cycle strobe. SDA is driven open-drain: a high `sda_oe` pulls the line low.

Top module: `i2c_regport`

## Requirements
- R1: SCL and SDA pass through a two-stage synchroniser. A START (SDA falls while SCL is high) begins reception of an address byte from any state, and this includes a repeated START in the middle of a transaction.
- R2: The slave address is {4'b0010, s2, addr_strap[1], addr_strap[0]}. Here s2 is the value of addr_strap[2] captured while rst_n is low and held unchanged after reset. Address byte bits 7:1 must equal this value, and bit 0 is R/W (1 = read, 0 = write). On a match the slave pulls SDA low during the ninth clock.
- R3: On an address mismatch the slave leaves SDA released during the ninth clock. It issues no strobe and ignores every byte until the next START.
- R4: In a write transaction the first byte after the address loads the pointer. Bit 7 is the auto-increment flag. The low REG_AW bits of bits 6:0 give the register index, so the index wraps modulo 2**REG_AW. The byte is acknowledged.
- R5: Each later byte of a write transaction produces one single-cycle `reg_we` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The slave acknowledges the byte.
- R6: With the auto-increment flag set, the pointer advances by one (modulo 2**REG_AW) after each data byte written or fetched. With the flag clear, the pointer does not move.
- R7: With R/W = 1 the slave transmits the register selected by the pointer, MSB first. It fetches that register with a single-cycle `reg_re` pulse, and `reg_we` and `reg_re` are never high together.
- R8: After each transmitted byte the slave samples the master's acknowledge. On ACK (SDA low) it fetches and sends the next byte. On NACK it keeps SDA released until the next START or STOP.
- R9: `sda_oe` changes only while the synchronised SCL is low.
- R10: A STOP, or a START received part-way through a byte, abandons the byte without any register strobe. After a STOP the slave is idle with SDA released.
- R11: While rst_n is low, `sda_oe`, `reg_we` and `reg_re` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low |
| addr_strap | input | 3 | Address strap bits; bit 2 is captured during reset |
| reg_addr | output | REG_AW | Register index (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |
| reg_re | output | 1 | Single-cycle register fetch strobe |

## Verification
The hardest situations to reach from the ports are the aborted transfers. One case is a STOP or repeated START that arrives after only a few bits of a byte. The other is a master NACK, after which the slave must stay silent while the master keeps toggling SCL. The bench uses a partial-byte task that clocks an arbitrary number of bits before it issues the bus condition. After a NACK it clocks nine further bits with SDA released and checks that the line stays high. Around these cases it sweeps all 128 addresses against a strap value that changes after reset. It also runs auto-increment bursts that wrap past the top of the register file.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int REG_AW = 4,
  parameter logic [3:0] ADDR_PREFIX = 4'b0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        addr_strap,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata,
  output logic              reg_re
);
  localparam logic [REG_AW-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  st_t st;
  kind_t kind;
  logic [1:0] scl_sy, sda_sy;
  logic scl_q, sda_q, ad2_lat, rw, ackd, ptr_ai;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [REG_AW-1:0] ptr_a;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire [6:0] own_addr = {ADDR_PREFIX, ad2_lat, addr_strap[1:0]};
  wire rx_done = fall && st == S_RX && cnt == 4'd8;

  assign reg_we    = rx_done && kind == K_DATA;
  assign reg_wdata = sh;
  assign reg_addr  = ptr_a;
  assign reg_re    = fall && ((st == S_RXACK && rw && kind == K_ADDR) ||
                              (st == S_TXACK && ackd));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;               sda_q  <= sda_s;
    end

  always_ff @(posedge clk)
    if (!rst_n) ad2_lat <= addr_strap[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_ADDR; cnt <= '0; sh <= '0; rw <= 1'b0;
      ackd <= 1'b0; ptr_ai <= 1'b0; ptr_a <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; kind <= K_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (rise) begin
            sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
          end else if (rx_done) begin
            if (kind == K_ADDR) begin
              if (sh[7:1] == own_addr) begin
                rw <= sh[0]; sda_oe <= 1'b1; st <= S_RXACK;
              end else st <= S_IDLE;
            end else begin
              sda_oe <= 1'b1; st <= S_RXACK;
              if (kind == K_PTR) begin
                ptr_ai <= sh[7]; ptr_a <= sh[REG_AW-1:0];
              end else if (ptr_ai) ptr_a <= ptr_a + ONE;
            end
          end
        S_RXACK:
          if (fall) begin
            cnt <= '0;
            if (reg_re) begin
              sh <= reg_rdata; sda_oe <= ~reg_rdata[7]; st <= S_TX;
              if (ptr_ai) ptr_a <= ptr_a + ONE;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
              kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        S_TX:
          if (rise) cnt <= cnt + 4'd1;
          else if (fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0; st <= S_TXACK;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
            end
          end
        S_TXACK:
          if (rise) ackd <= ~sda_s;
          else if (fall) begin
            cnt <= '0;
            if (ackd) begin
              sh <= reg_rdata; sda_oe <= ~reg_rdata[7]; st <= S_TX;
              if (ptr_ai) ptr_a <= ptr_a + ONE;
            end else st <= S_IDLE;
          end
        default: ;
      endcase
    end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re)); // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (!sda_oe && st == S_IDLE)); // R10
  AST_AI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ptr_ai) |=> reg_addr == $past(reg_addr) + ONE); // R6
  AST_NOAI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !ptr_ai) |=> $stable(reg_addr)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R3
endmodule

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;
  localparam int Q = 10;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m_low = 1'b0;
  logic [2:0] strap = 3'b100;
  logic sda_oe, reg_we, reg_re;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  logic sda_line;
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0, r9_bad = 0;
  logic prev_oe = 1'b0;

  assign sda_line  = !(sda_m_low || sda_oe);
  assign reg_rdata = mem[reg_addr];

  i2c_regport u_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .addr_strap(strap), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .reg_re(reg_re));

  always @(posedge clk) begin
    if (reg_we) begin mem[reg_addr] <= reg_wdata; we_cnt++; end
    if (reg_re) re_cnt++;
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) r9_bad++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] vpat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic half; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    sda_m_low = 1'b0; half; scl_m = 1'b1; half; sda_m_low = 1'b1; half; scl_m = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m_low = 1'b1; half; scl_m = 1'b1; half; sda_m_low = 1'b0; half;
  endtask

  task automatic clk_bit(input bit b, output bit s);
    sda_m_low = !b; half; scl_m = 1'b1; half; s = sda_line; scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    bit s;
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    send_bits(b, 8);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(!ack, s);
  endtask

  task automatic do_reset(input logic [2:0] st_rst);
    strap = st_rst; rst_n = 1'b0;
    repeat (6) @(negedge clk);
    check_eq("R11 sda_oe in reset", int'(sda_oe), 0);
    check_eq("R11 strobes in reset", int'({reg_we, reg_re}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit ack, s;
    logic [7:0] b;
    int w0, r0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    do_reset(3'b100);
    strap = 3'b011;

    // R2/R3 sweep: latched bit2=1, live bits 1:0=11 -> 0x17
    for (int a = 0; a < 128; a++) begin
      bus_start; send_byte({7'(a), 1'b0}, ack); bus_stop;
      if (a == 7'h17) check_eq("R2 address match ack", int'(ack), 1);
      else            check_eq("R3 address mismatch nack", int'(ack), 0);
    end
    check_eq("R3 no write strobe during sweep", we_cnt, 0);

    // R3: bytes after a mismatch are ignored
    bus_start; send_byte(8'h20, ack);
    send_byte(8'h80, ack); check_eq("R3 pointer byte ignored", int'(ack), 0);
    send_byte(8'h55, ack); check_eq("R3 data byte ignored", int'(ack), 0);
    bus_stop;
    check_eq("R3 no strobe after mismatch", we_cnt, 0);

    // R4/R5/R6 auto-increment write burst
    bus_start; send_byte(8'h2E, ack); check_eq("R2 write address ack", int'(ack), 1);
    send_byte(8'h80, ack); check_eq("R4 pointer ack", int'(ack), 1);
    for (int i = 0; i < 16; i++) begin
      send_byte(vpat(i), ack); check_eq("R5 data ack", int'(ack), 1);
    end
    bus_stop;
    check_eq("R5 write strobe count", we_cnt, 16);
    for (int i = 0; i < 16; i++) check_eq("R6 burst write content", int'(mem[i]), int'(vpat(i)));

    // R6/R7/R8 auto-increment read wrapping; pointer byte 0xF3 -> index 3
    bus_start; send_byte(8'h2E, ack); send_byte(8'hF3, ack);
    check_eq("R4 pointer with high bits ack", int'(ack), 1);
    bus_start; send_byte(8'h2F, ack); check_eq("R1 repeated start read ack", int'(ack), 1);
    r0 = re_cnt;
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, b);
      check_eq("R7 read burst byte", int'(b), int'(vpat((3 + i) % 16)));
    end
    check_eq("R8 fetch count", re_cnt - r0, 16);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s); check_eq("R8 quiet after nack", int'(s), 1);
    end
    bus_stop;

    // R6 no auto-increment write
    w0 = we_cnt;
    bus_start; send_byte(8'h2E, ack); send_byte(8'h05, ack);
    send_byte(8'hA1, ack); send_byte(8'hB2, ack); send_byte(8'hC3, ack);
    bus_stop;
    check_eq("R5 fixed-pointer strobes", we_cnt - w0, 3);
    check_eq("R6 fixed pointer last write", int'(mem[5]), 8'hC3);
    check_eq("R6 neighbour untouched", int'(mem[6]), int'(vpat(6)));

    // R6/R7 no auto-increment read
    bus_start; send_byte(8'h2E, ack); send_byte(8'h09, ack);
    bus_start; send_byte(8'h2F, ack);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, b); check_eq("R7 fixed-pointer read", int'(b), int'(vpat(9)));
    end
    bus_stop;

    // R10 STOP mid-byte
    w0 = we_cnt;
    bus_start; send_byte(8'h2E, ack); send_byte(8'h86, ack);
    send_bits(8'hEE, 4); bus_stop;
    check_eq("R10 stop mid-byte no strobe", we_cnt - w0, 0);
    bus_start; send_byte(8'h2F, ack); check_eq("R10 fresh after stop", int'(ack), 1);
    recv_byte(1'b0, b); bus_stop;
    check_eq("R10 pointer kept, nothing written", int'(b), int'(vpat(6)));

    // R1/R10 repeated START mid-byte
    w0 = we_cnt;
    bus_start; send_byte(8'h2E, ack); send_bits(8'h5A, 5);
    bus_start; send_byte(8'h2E, ack); check_eq("R1 start mid-byte readdress", int'(ack), 1);
    send_byte(8'h0A, ack); send_byte(8'h77, ack); bus_stop;
    check_eq("R10 single strobe after abort", we_cnt - w0, 1);
    check_eq("R1 write after restart", int'(mem[10]), 8'h77);

    // R2 second reset: strap 000 latched, then bit2 raised
    do_reset(3'b000);
    strap = 3'b100;
    bus_start; send_byte(8'h20, ack); bus_stop;
    check_eq("R2 latched strap bit2=0 matches 0x10", int'(ack), 1);
    bus_start; send_byte(8'h28, ack); bus_stop;
    check_eq("R2 live strap bit2 ignored (0x14)", int'(ack), 0);

    check_eq("R9 sda_oe moved only with scl low", r9_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule